// File: doc/BRIEF.md
# Shared-Plane Voltage/Frequency State Arbiter

This block picks a single operating point, high or low voltage/frequency, for a pair of cores that draw from one supply plane. Each core reports its activity level. The shared point rises as soon as any core asks for high activity. It falls back only after every core has stayed at sleep or low activity for a programmable dwell.

Every change of point is carried out through two request/acknowledge handshakes, one with the voltage regulator and one with the clock generator. The order is fixed so that the clock is never fast while the supply is low. On a raise the voltage goes up first. On a drop the clock comes down first.

After reset the part sits at the low point and stays there until firmware signals that boot is complete. Each completed change is announced to every thread with a one-cycle broadcast pulse. Each core has its own thermal trip input. A trip throttles that core alone, and while it is active it holds off any raise.

Top module: `vf_plane_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, vreg_req_o, vreg_hi_o, clk_req_o, clk_hi_o, bcast_o and throttle_o are all 0.
- R2: Until fw_done_i has been sampled high, vreg_hi_o, vreg_req_o and clk_hi_o stay 0, whatever the activity inputs show.
- R3: Activity codes per core are 0 asleep, 1 low, 2 high and 3 high (bit 1 set means high). Core c uses act_i[2c+1:2c]. When the block is settled low, with no trip and at least one core high, the block asserts vreg_req_o with vreg_hi_o=1 in the next cycle. With no core high, it stays settled.
- R4: On a raise, clk_hi_o becomes 1 only in the cycle after vreg_ack_i was sampled high, and clk_req_o is asserted in that same cycle.
- R5: On a drop, clk_req_o with clk_hi_o=0 is issued first. vreg_hi_o stays 1 until clk_ack_i is sampled, and vreg_req_o with vreg_hi_o=0 follows in the next cycle.
- R6: At the high point, the drop starts after dwell_i consecutive sampled cycles with no core high (a value of 0 counts as 1). Any cycle with a core high restarts the count.
- R7: Demand changes during a transition do not abort it. Once the transition completes, the latest demand is re-evaluated.
- R8: While either bit of therm_i is set, no raise from the low point is started. A raise may start in the cycle after the trip clears.
- R9: throttle_o[c] equals therm_i[c] of the previous cycle, for each core independently.
- R10: bcast_o pulses for exactly one cycle on the first cycle at a newly reached stable point, including the exit from boot.
- R11: While a request is outstanding without its acknowledge, the request stays asserted and its target level stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| act_i | input | 2*NCORE | Per-core activity codes |
| therm_i | input | NCORE | Per-core thermal trip |
| fw_done_i | input | 1 | Firmware boot-complete event |
| dwell_i | input | CW | Low-demand dwell in cycles before a drop |
| vreg_req_o | output | 1 | Voltage regulator request |
| vreg_hi_o | output | 1 | Voltage target, 1 = high |
| vreg_ack_i | input | 1 | Voltage regulator acknowledge |
| clk_req_o | output | 1 | Clock generator request |
| clk_hi_o | output | 1 | Frequency target, 1 = high |
| clk_ack_i | input | 1 | Clock generator acknowledge |
| throttle_o | output | NCORE | Per-core throttle |
| bcast_o | output | 1 | Point-change broadcast pulse |

## Verification
A wrong sequencer state shows up at the handshake pins within one cycle. It appears as a request that starts early or late, a target level that flips while unacknowledged, or a frequency target that is high while the voltage target is low. A wrong dwell count shows up as a clock request issued one or more cycles off the programmed edge, so the bench samples the exact cycle either side of it. A stale pending demand shows up as a missing or spurious voltage request in the cycle right after a point is reached.

// File: rtl/vf_pkg.sv
package vf_pkg;
  typedef enum logic [2:0] {
    S_BOOT, S_LOW, S_UPV, S_UPF, S_HIGH, S_DNF, S_DNV
  } vf_state_e;

  function automatic logic act_is_hi(input logic [1:0] a);
    return a[1];
  endfunction
endpackage

// File: rtl/vf_demand.sv
module vf_demand #(
  parameter int NCORE = 2
) (
  input  logic [2*NCORE-1:0] act_i,
  input  logic [NCORE-1:0]   therm_i,
  output logic               dem_hi_o,
  output logic               trip_o
);
  import vf_pkg::*;
  logic [NCORE-1:0] hi_vec;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign hi_vec[c] = act_is_hi(act_i[2*c +: 2]);
  end

  assign dem_hi_o = |hi_vec;
  assign trip_o   = |therm_i;
endmodule

// File: rtl/vf_dwell.sv
module vf_dwell #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] dwell_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nx;
  logic [CW:0]   lim;

  assign cnt_nx   = {1'b0, cnt_q} + 1'b1;
  assign lim      = (dwell_i == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, dwell_i};
  assign expire_o = run_i && (cnt_nx >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                       cnt_q <= cnt_nx[CW-1:0];
  end
endmodule

// File: rtl/vf_throttle.sv
module vf_throttle #(
  parameter int NCORE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCORE-1:0] therm_i,
  output logic [NCORE-1:0] throttle_o
);
  for (genvar c = 0; c < NCORE; c++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) throttle_o[c] <= 1'b0;
      else         throttle_o[c] <= therm_i[c];
    end
  end
endmodule

// File: rtl/vf_plane_ctrl.sv
module vf_plane_ctrl #(
  parameter int NCORE = 2,
  parameter int CW    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*NCORE-1:0] act_i,
  input  logic [NCORE-1:0]   therm_i,
  input  logic               fw_done_i,
  input  logic [CW-1:0]      dwell_i,
  output logic               vreg_req_o,
  output logic               vreg_hi_o,
  input  logic               vreg_ack_i,
  output logic               clk_req_o,
  output logic               clk_hi_o,
  input  logic               clk_ack_i,
  output logic [NCORE-1:0]   throttle_o,
  output logic               bcast_o
);
  import vf_pkg::*;

  vf_state_e state_q, state_d;
  logic dem_hi, trip, raise_ok, expire, bcast_q;

  vf_demand #(.NCORE(NCORE)) u_dem (
    .act_i(act_i), .therm_i(therm_i), .dem_hi_o(dem_hi), .trip_o(trip)
  );

  vf_dwell #(.CW(CW)) u_dwell (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i((state_q == S_HIGH) && !dem_hi),
    .dwell_i(dwell_i), .expire_o(expire)
  );

  vf_throttle #(.NCORE(NCORE)) u_thr (
    .clk_i(clk_i), .rst_ni(rst_ni), .therm_i(therm_i), .throttle_o(throttle_o)
  );

  assign raise_ok = dem_hi && !trip;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_BOOT: if (fw_done_i) state_d = raise_ok ? S_UPV : S_LOW;
      S_LOW:  if (raise_ok)  state_d = S_UPV;
      S_UPV:  if (vreg_ack_i) state_d = S_UPF;
      S_UPF:  if (clk_ack_i)  state_d = S_HIGH;
      S_HIGH: if (expire)     state_d = S_DNF;
      S_DNF:  if (clk_ack_i)  state_d = S_DNV;
      S_DNV:  if (vreg_ack_i) state_d = S_LOW;
      default: state_d = S_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_BOOT;
      bcast_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bcast_q <= (state_d != state_q) && (state_d == S_LOW || state_d == S_HIGH);
    end
  end

  // voltage target leads frequency on the way up, trails it on the way down
  assign vreg_hi_o  = (state_q == S_UPV) || (state_q == S_UPF) ||
                      (state_q == S_HIGH) || (state_q == S_DNF);
  assign clk_hi_o   = (state_q == S_UPF) || (state_q == S_HIGH);
  assign vreg_req_o = (state_q == S_UPV) || (state_q == S_DNV);
  assign clk_req_o  = (state_q == S_UPF) || (state_q == S_DNF);
  assign bcast_o    = bcast_q;
endmodule

// File: rtl/vf_plane_ctrl_chk.sv
module vf_plane_ctrl_chk #(
  parameter int NCORE = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NCORE-1:0] therm_i,
  input logic             fw_done_i,
  input logic             vreg_req_o,
  input logic             vreg_hi_o,
  input logic             vreg_ack_i,
  input logic             clk_req_o,
  input logic             clk_hi_o,
  input logic             clk_ack_i,
  input logic [NCORE-1:0] throttle_o,
  input logic             bcast_o
);
  logic fw_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fw_seen_q <= 1'b0;
    else if (fw_done_i) fw_seen_q <= 1'b1;
  end

  assert_boot_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fw_seen_q |-> (!vreg_hi_o && !vreg_req_o && !clk_hi_o));

  assert_freq_under_volt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_hi_o |-> vreg_hi_o);

  assert_raise_after_vack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_hi_o) |-> ($past(vreg_ack_i) && clk_req_o));

  assert_drop_after_cack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vreg_hi_o) |-> ($past(clk_ack_i) && vreg_req_o));

  assert_trip_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_seen_q && !vreg_hi_o && !vreg_req_o && (|therm_i)) |=> !vreg_hi_o);

  assert_throttle_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_seen_q |=> (throttle_o == $past(therm_i)));

  assert_bcast_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |=> !bcast_o);

  assert_vreq_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vreg_req_o && !vreg_ack_i) |=> (vreg_req_o && $stable(vreg_hi_o)));

  assert_creq_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_req_o && !clk_ack_i) |=> (clk_req_o && $stable(clk_hi_o)));
endmodule

bind vf_plane_ctrl vf_plane_ctrl_chk #(.NCORE(NCORE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .therm_i(therm_i), .fw_done_i(fw_done_i),
  .vreg_req_o(vreg_req_o), .vreg_hi_o(vreg_hi_o), .vreg_ack_i(vreg_ack_i),
  .clk_req_o(clk_req_o), .clk_hi_o(clk_hi_o), .clk_ack_i(clk_ack_i),
  .throttle_o(throttle_o), .bcast_o(bcast_o)
);

// File: tb/tb_vf_plane_ctrl.sv
module tb_vf_plane_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 2;
  localparam int CW = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2*NCORE-1:0] act = '0;
  logic [NCORE-1:0] therm = '0;
  logic fw_done = 1'b0;
  logic [CW-1:0] dwell = 8'd1;
  logic vreg_req, vreg_hi, clk_req, clk_hi, bcast;
  logic [NCORE-1:0] throttle;
  logic auto_ack = 1'b0;
  logic va_man = 1'b0, ca_man = 1'b0;
  logic va_auto, ca_auto;
  logic [3:0] vcnt, ccnt;
  logic vack, cack;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign vack = auto_ack ? va_auto : va_man;
  assign cack = auto_ack ? ca_auto : ca_man;

  vf_plane_ctrl #(.NCORE(NCORE), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act), .therm_i(therm),
    .fw_done_i(fw_done), .dwell_i(dwell),
    .vreg_req_o(vreg_req), .vreg_hi_o(vreg_hi), .vreg_ack_i(vack),
    .clk_req_o(clk_req), .clk_hi_o(clk_hi), .clk_ack_i(cack),
    .throttle_o(throttle), .bcast_o(bcast)
  );

  // automatic responders with fixed latency
  always_ff @(posedge clk) begin
    if (!auto_ack) begin
      va_auto <= 1'b0; ca_auto <= 1'b0; vcnt <= '0; ccnt <= '0;
    end else begin
      if (vreg_req && !va_auto) begin
        if (vcnt == LAT) begin va_auto <= 1'b1; vcnt <= '0; end
        else vcnt <= vcnt + 1'b1;
      end else begin va_auto <= 1'b0; vcnt <= '0; end
      if (clk_req && !ca_auto) begin
        if (ccnt == LAT) begin ca_auto <= 1'b1; ccnt <= '0; end
        else ccnt <= ccnt + 1'b1;
      end else begin ca_auto <= 1'b0; ccnt <= '0; end
    end
  end

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_vack();
    va_man = 1'b1; cyc(1); va_man = 1'b0;
  endtask

  task automatic pulse_cack();
    ca_man = 1'b1; cyc(1); ca_man = 1'b0;
  endtask

  initial begin
    cyc(2);
    chk("R1 reset vreg_req", vreg_req, 0);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 vreg_req", vreg_req, 0);
    chk("R1 vreg_hi", vreg_hi, 0);
    chk("R1 clk_req", clk_req, 0);
    chk("R1 clk_hi", clk_hi, 0);
    chk("R1 throttle", throttle, 0);
    chk("R1 bcast", bcast, 0);

    // boot hold with full demand
    act = {2'd2, 2'd3};
    cyc(10);
    chk("R2 no raise before fw", vreg_req, 0);
    chk("R2 low volt before fw", vreg_hi, 0);
    chk("R2 low clk before fw", clk_hi, 0);

    // firmware release, raise sequence by hand
    fw_done = 1'b1; cyc(1); fw_done = 1'b0;
    chk("R3 vreg_req after release", vreg_req, 1);
    chk("R3 vreg_hi target", vreg_hi, 1);
    chk("R4 clk not raised before vack", clk_hi, 0);
    chk("R10 no bcast mid raise", bcast, 0);
    cyc(3);
    chk("R11 vreg_req held", vreg_req, 1);
    chk("R11 vreg_hi held", vreg_hi, 1);
    chk("R4 clk still low", clk_hi, 0);
    pulse_vack();
    chk("R4 clk_hi after vack", clk_hi, 1);
    chk("R4 clk_req after vack", clk_req, 1);
    chk("R4 vreg_req released", vreg_req, 0);
    cyc(2);
    chk("R11 clk_req held", clk_req, 1);
    pulse_cack();
    chk("R10 bcast at high", bcast, 1);
    chk("R4 clk_req done", clk_req, 0);
    cyc(1);
    chk("R10 bcast one cycle", bcast, 0);

    // dwell with restart
    dwell = 8'd5;
    act = {2'd1, 2'd0};
    cyc(3);
    act = {2'd0, 2'd2};
    cyc(1);
    act = {2'd0, 2'd1};
    cyc(4);
    chk("R6 no drop before dwell after restart", clk_req, 0);
    cyc(1);
    chk("R6 drop at dwell", clk_req, 1);
    chk("R5 clk target low first", clk_hi, 0);
    chk("R5 volt still high", vreg_hi, 1);
    cyc(2);
    chk("R5 no vreg_req before cack", vreg_req, 0);
    chk("R5 vreg_hi held before cack", vreg_hi, 1);
    pulse_cack();
    chk("R5 vreg_req after cack", vreg_req, 1);
    chk("R5 vreg_hi low after cack", vreg_hi, 0);
    chk("R5 clk_req done", clk_req, 0);

    // demand rises during drop: held pending
    act = {2'd2, 2'd0};
    cyc(2);
    chk("R7 drop not aborted", vreg_req, 1);
    chk("R7 target still low", vreg_hi, 0);
    pulse_vack();
    chk("R10 bcast at low", bcast, 1);
    chk("R7 vreg_req off at low", vreg_req, 0);
    cyc(1);
    chk("R7 pending demand raises", vreg_req, 1);
    chk("R7 raise target", vreg_hi, 1);
    pulse_vack();
    pulse_cack();
    chk("R7 reached high", clk_hi, 1);

    // settle low with auto responders, then thermal block
    auto_ack = 1'b1;
    dwell = 8'd0;
    act = '0;
    cyc(25);
    chk("R6 dwell zero drops", vreg_hi, 0);
    chk("R6 settled", vreg_req, 0);
    therm = 2'b01;
    act = {2'd0, 2'd2};
    cyc(10);
    chk("R8 trip core0 blocks", vreg_req, 0);
    therm = 2'b10;
    cyc(5);
    chk("R8 trip core1 blocks", vreg_req | vreg_hi, 0);
    therm = 2'b00;
    cyc(1);
    chk("R8 raise after clear", vreg_req, 1);
    cyc(25);
    chk("R8 reached high", clk_hi, 1);

    // throttle independence sweep
    for (int v = 0; v < 4; v++) begin
      therm = v[1:0];
      cyc(1);
      chk("R9 throttle follows", throttle, v);
    end
    therm = '0;
    cyc(1);
    chk("R9 throttle clears", throttle, 0);

    // activity sweep from settled low
    for (int a0 = 0; a0 < 4; a0++) begin
      for (int a1 = 0; a1 < 4; a1++) begin
        act = '0;
        cyc(30);
        chk("R3 settled low before combo", vreg_hi | vreg_req | clk_req, 0);
        act = {a1[1:0], a0[1:0]};
        cyc(1);
        chk("R3 raise decision", vreg_req, int'(a0[1] | a1[1]));
        chk("R3 target on raise", vreg_hi, int'(a0[1] | a1[1]));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule